// File: doc/BRIEF.md
# Dual-Wiper Register Controller with Nonvolatile Backup

This block is the digital core of a two-channel digital potentiometer. It keeps two 8-bit wiper registers and a sixteen-byte nonvolatile store. The store is modelled as a register array, and each write to it holds the block busy for a set number of cycles. Locations 0 and 1 of the store back up wiper 0 and wiper 1. Locations 2 to 15 are spare user bytes. Each wiper register drives a one-hot bank of 256 tap-select lines, one line for each wiper position.

Commands enter on a parallel port that carries a 4-bit operation code, a 4-bit address and a data byte, with a valid/ready handshake. The supported operations are: NOP, load wiper, save wiper, restore wiper, restore wiper with read mode, write user byte and read user byte. A read-mode power flag is set by the two operations that read the store for the host. Only a NOP returns the block to low-power idle. A command with an unknown code, or with an address outside the range for its operation, is dropped and reported on an error pulse.

The controller has four states:
- BOOT_A copies store location 0 into wiper 0 and always moves on to BOOT_B.
- BOOT_B copies location 1 into wiper 1 and always moves on to IDLE.
- IDLE is the only state in which commands are accepted. An accepted legal save or user write moves the controller to BUSY. Any other accepted command leaves it in IDLE.
- BUSY counts out the store latency and then returns to IDLE.

Top module: `potcore_top`

## Requirements
- R1: Reset sets all 16 store bytes to INIT_BYTE and clears both wipers and the read-mode flag. On the first clock edge after reset is released, wiper 0 takes store location 0. On the second edge, wiper 1 takes location 1. `cmd_ready` stays low until both copies are done.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only in IDLE. A command held valid while `cmd_ready` is low waits and is taken later, unchanged.
- R3: Code 11 (load) with address 0 or 1 writes `cmd_data` into that wiper on the accepting edge.
- R4: Code 2 (save) with address 0 or 1 copies the current wiper value into store location 0 or 1.
- R5: Code 3 (user write) with address 2 to 15 writes `cmd_data` into that store location.
- R6: After an accepted save or user write, `busy` is high and `cmd_ready` is low for exactly STORE_LAT cycles.
- R7: Code 8 (restore) with address 0 or 1 copies store location 0 or 1 into the matching wiper and leaves the read-mode flag unchanged.
- R8: Code 1 (restore with read mode) with address 0 or 1 does the same copy and also sets `read_mode`.
- R9: Code 9 (user read) with address 2 to 15 puts the stored byte on `rd_data` and pulses `rd_valid` for the one cycle after the accepting edge. It also sets `read_mode`.
- R10: Only code 0 (NOP) clears `read_mode`. Every other accepted command leaves the flag set if it was set.
- R11: A command is illegal if its code is not 0, 1, 2, 3, 8, 9 or 11, or if its address is out of range for its code. An illegal command changes no wiper, store byte or flag, starts no busy period, and raises `cmd_err` for the one cycle after it is accepted.
- R12: `tap0` and `tap1` each have exactly one bit set, at the index equal to the value of wiper 0 or wiper 1. The taps follow the wiper in the same cycle the wiper changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_code | input | 4 | Operation code |
| cmd_addr | input | 4 | Wiper or store address |
| cmd_data | input | 8 | Data byte for load and user write |
| rd_valid | output | 1 | One-cycle strobe for a user read |
| rd_data | output | 8 | Byte returned by the last user read |
| cmd_err | output | 1 | One-cycle strobe for an illegal command |
| busy | output | 1 | A store write is in progress |
| read_mode | output | 1 | Read-mode power state flag |
| wiper0 | output | 8 | Wiper 0 register |
| wiper1 | output | 8 | Wiper 1 register |
| tap0 | output | 256 | One-hot tap select, channel 0 |
| tap1 | output | 256 | One-hot tap select, channel 1 |

## Verification
The store has no port of its own, so a corrupted byte shows up only when a later restore or user read returns it. The bench therefore follows every store change with a read-back and compares the result against a model of the store. A busy counter that is off by one shows up at once, as a `cmd_ready` low window of the wrong length. A wrong power-state flag or a missed illegal-command check is visible on `read_mode` or `cmd_err` in the cycle after the accepting edge. A bad decoder or wiper register shows up on the tap lines in the same cycle.

// File: rtl/potcore_pkg.sv
package potcore_pkg;
    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_RESTORE_RM = 4'd1,
        OP_SAVE       = 4'd2,
        OP_USER_WR    = 4'd3,
        OP_RESTORE    = 4'd8,
        OP_USER_RD    = 4'd9,
        OP_LOAD       = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        ST_BOOT_A,
        ST_BOOT_B,
        ST_IDLE,
        ST_BUSY
    } state_e;

    localparam int NUM_WIPERS = 2;
endpackage

// File: rtl/potcore_nvstore.sv
module potcore_nvstore #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter logic [DATA_W-1:0] INIT_BYTE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= INIT_BYTE;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R4/R5: a write lands in the addressed byte on the next cycle
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/potcore_cmd_check.sv
module potcore_cmd_check
    import potcore_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [3:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              legal,
    output logic              op_nop,
    output logic              op_load,
    output logic              op_save,
    output logic              op_restore,
    output logic              op_user_wr,
    output logic              op_user_rd,
    output logic              op_sets_rm
);
    logic addr_wiper;

    assign addr_wiper = (addr < ADDR_W'(NUM_WIPERS));

    always_comb begin
        op_nop     = 1'b0;
        op_load    = 1'b0;
        op_save    = 1'b0;
        op_restore = 1'b0;
        op_user_wr = 1'b0;
        op_user_rd = 1'b0;
        op_sets_rm = 1'b0;
        legal      = 1'b0;
        case (code)
            OP_NOP: begin
                op_nop = 1'b1;
                legal  = 1'b1;
            end
            OP_LOAD: begin
                op_load = 1'b1;
                legal   = addr_wiper;
            end
            OP_SAVE: begin
                op_save = 1'b1;
                legal   = addr_wiper;
            end
            OP_RESTORE: begin
                op_restore = 1'b1;
                legal      = addr_wiper;
            end
            OP_RESTORE_RM: begin
                op_restore = 1'b1;
                op_sets_rm = 1'b1;
                legal      = addr_wiper;
            end
            OP_USER_WR: begin
                op_user_wr = 1'b1;
                legal      = !addr_wiper;
            end
            OP_USER_RD: begin
                op_user_rd = 1'b1;
                op_sets_rm = 1'b1;
                legal      = !addr_wiper;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/potcore_tap_decode.sv
module potcore_tap_decode #(
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] taps
);
    localparam int TAPS = 1 << SEL_W;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign taps[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/potcore_top.sv
module potcore_top
    import potcore_pkg::*;
#(
    parameter int WIPER_W = 8,
    parameter int ADDR_W = 4,
    parameter int STORE_LAT = 4,
    parameter logic [WIPER_W-1:0] INIT_BYTE = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [3:0]               cmd_code,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [WIPER_W-1:0]       cmd_data,
    output logic                     rd_valid,
    output logic [WIPER_W-1:0]       rd_data,
    output logic                     cmd_err,
    output logic                     busy,
    output logic                     read_mode,
    output logic [WIPER_W-1:0]       wiper0,
    output logic [WIPER_W-1:0]       wiper1,
    output logic [(1<<WIPER_W)-1:0]  tap0,
    output logic [(1<<WIPER_W)-1:0]  tap1
);
    localparam int CNT_W = $clog2(STORE_LAT + 1);

    state_e               state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [WIPER_W-1:0]   wiper_q [NUM_WIPERS];
    logic                 accept;
    logic                 legal, op_nop, op_load, op_save, op_restore;
    logic                 op_user_wr, op_user_rd, op_sets_rm;
    logic                 st_we;
    logic [ADDR_W-1:0]    st_raddr;
    logic [WIPER_W-1:0]   st_rdata, st_wdata;
    logic                 sel;

    assign cmd_ready = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_BUSY);
    assign accept    = cmd_valid && cmd_ready;
    assign sel       = cmd_addr[0];

    potcore_cmd_check #(.ADDR_W(ADDR_W)) u_check (
        .code       (cmd_code),
        .addr       (cmd_addr),
        .legal      (legal),
        .op_nop     (op_nop),
        .op_load    (op_load),
        .op_save    (op_save),
        .op_restore (op_restore),
        .op_user_wr (op_user_wr),
        .op_user_rd (op_user_rd),
        .op_sets_rm (op_sets_rm)
    );

    assign st_we    = accept && legal && (op_save || op_user_wr);
    assign st_wdata = op_save ? wiper_q[sel] : cmd_data;

    always_comb begin
        unique case (state_q)
            ST_BOOT_A: st_raddr = ADDR_W'(0);
            ST_BOOT_B: st_raddr = ADDR_W'(1);
            default:   st_raddr = cmd_addr;
        endcase
    end

    potcore_nvstore #(
        .DATA_W    (WIPER_W),
        .ADDR_W    (ADDR_W),
        .INIT_BYTE (INIT_BYTE)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (cmd_addr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT_A;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_BOOT_A: state_d = ST_BOOT_B;
            ST_BOOT_B: state_d = ST_IDLE;
            ST_IDLE: begin
                if (st_we) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_W'(STORE_LAT - 1);
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q[0] <= '0;
            wiper_q[1] <= '0;
            read_mode  <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            cmd_err    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            cmd_err  <= 1'b0;
            if (state_q == ST_BOOT_A) wiper_q[0] <= st_rdata;
            if (state_q == ST_BOOT_B) wiper_q[1] <= st_rdata;
            if (accept) begin
                if (!legal) begin
                    cmd_err <= 1'b1;
                end else begin
                    if (op_load)    wiper_q[sel] <= cmd_data;
                    if (op_restore) wiper_q[sel] <= st_rdata;
                    if (op_nop)     read_mode    <= 1'b0;
                    if (op_sets_rm) read_mode    <= 1'b1;
                    if (op_user_rd) begin
                        rd_valid <= 1'b1;
                        rd_data  <= st_rdata;
                    end
                end
            end
        end
    end

    assign wiper0 = wiper_q[0];
    assign wiper1 = wiper_q[1];

    potcore_tap_decode #(.SEL_W(WIPER_W)) u_tap0 (.sel(wiper0), .taps(tap0));
    potcore_tap_decode #(.SEL_W(WIPER_W)) u_tap1 (.sel(wiper1), .taps(tap1));

    assert_tap0_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tap0[wiper0] && ($countones(tap0) == 1));
    assert_tap1_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tap1[wiper1] && ($countones(tap1) == 1));
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_ready));
    assert_rdvalid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_ready && (cmd_code == OP_USER_RD)));
    assert_rm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_mode) |-> $past(cmd_valid && cmd_ready && (cmd_code == OP_NOP)));
    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid && cmd_ready));
    assert_err_no_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !busy);
endmodule

// File: tb/tb_potcore_top.sv
module tb_potcore_top;
    localparam int LAT = 4;
    localparam logic [7:0] INIT = 8'h5A;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [3:0]   cmd_code = '0;
    logic [3:0]   cmd_addr = '0;
    logic [7:0]   cmd_data = '0;
    logic         rd_valid, cmd_err, busy, read_mode;
    logic [7:0]   rd_data, wiper0, wiper1;
    logic [255:0] tap0, tap1;

    int n_cmp = 0;
    int n_bad = 0;
    logic       s_err, s_rdv;
    logic [7:0] s_rdd;

    always #2.5 clk = ~clk;

    potcore_top #(.STORE_LAT(LAT), .INIT_BYTE(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err), .busy(busy),
        .read_mode(read_mode), .wiper0(wiper0), .wiper1(wiper1),
        .tap0(tap0), .tap1(tap1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Offer a command, wait for acceptance, land on the negedge after it
    task automatic issue(input logic [3:0] c, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_addr  = a;
        cmd_data  = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        s_err = cmd_err;
        s_rdv = rd_valid;
        s_rdd = rd_data;
    endtask

    task automatic count_busy(input string req);
        int n = 0;
        while (!cmd_ready && n < 100) begin
            if (!busy) begin
                n_cmp++; n_bad++;
                $display("FAIL %s busy low while ready low actual=0 expected=1", req);
            end
            n++;
            @(negedge clk);
        end
        chk(req, n, LAT);
    endtask

    task automatic check_taps(input string req);
        chk(req, tap0[wiper0], 1);
        chk(req, $countones(tap0), 1);
        chk(req, tap1[wiper1], 1);
        chk(req, $countones(tap1), 1);
    endtask

    task automatic t_reset();
        int n = 0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", cmd_ready, 0);
        chk("R1 wiper0 in reset", wiper0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wiper0 after first edge", wiper0, INIT);
        chk("R1 ready during boot", cmd_ready, 0);
        @(negedge clk);
        chk("R1 wiper1 after second edge", wiper1, INIT);
        chk("R1 ready after boot", cmd_ready, 1);
        chk("R1 read_mode idle", read_mode, 0);
        chk("R1 busy", busy, 0);
        check_taps("R12 taps after boot");
    endtask

    task automatic t_load();
        issue(4'd11, 4'd0, 8'h3C);
        chk("R3 load wiper0", wiper0, 8'h3C);
        chk("R3 no err", s_err, 0);
        chk("R12 tap0 at 3C", tap0[8'h3C], 1);
        issue(4'd11, 4'd1, 8'hF0);
        chk("R3 load wiper1", wiper1, 8'hF0);
        issue(4'd11, 4'd0, 8'h00);
        check_taps("R12 taps at 00");
        chk("R12 tap0 bit0", tap0[0], 1);
        issue(4'd11, 4'd0, 8'hFF);
        check_taps("R12 taps at FF");
        chk("R12 tap0 bit255", tap0[255], 1);
        issue(4'd11, 4'd0, 8'h3C);
        chk("R2 ready after load", cmd_ready, 1);
    endtask

    task automatic t_save_restore();
        issue(4'd2, 4'd0, 8'h00);
        chk("R4 save no err", s_err, 0);
        count_busy("R6 save wiper0 busy length");
        issue(4'd2, 4'd1, 8'h00);
        count_busy("R6 save wiper1 busy length");
        issue(4'd11, 4'd0, 8'h11);
        issue(4'd11, 4'd1, 8'h22);
        issue(4'd8, 4'd0, 8'h00);
        chk("R7 restore wiper0", wiper0, 8'h3C);
        chk("R7 wiper1 untouched", wiper1, 8'h22);
        chk("R7 read_mode unchanged", read_mode, 0);
        issue(4'd1, 4'd1, 8'h00);
        chk("R8 restore wiper1", wiper1, 8'hF0);
        chk("R8 read_mode set", read_mode, 1);
        issue(4'd11, 4'd0, 8'h77);
        chk("R10 read_mode kept by load", read_mode, 1);
        issue(4'd8, 4'd0, 8'h00);
        chk("R10 read_mode kept by restore", read_mode, 1);
        issue(4'd0, 4'd0, 8'h00);
        chk("R10 nop clears read_mode", read_mode, 0);
    endtask

    task automatic t_user();
        issue(4'd3, 4'd5, 8'hA5);
        count_busy("R6 user write busy length");
        issue(4'd9, 4'd5, 8'h00);
        chk("R9 rd_valid", s_rdv, 1);
        chk("R5 R9 data addr5", s_rdd, 8'hA5);
        chk("R9 read_mode set", read_mode, 1);
        @(negedge clk);
        chk("R9 rd_valid one cycle", rd_valid, 0);
        issue(4'd9, 4'd15, 8'h00);
        chk("R1 R9 unwritten addr15", s_rdd, INIT);
        issue(4'd3, 4'd2, 8'hC3);
        issue(4'd9, 4'd2, 8'h00);
        chk("R2 R9 read after busy wait", s_rdd, 8'hC3);
        chk("R9 rd_valid after wait", s_rdv, 1);
        issue(4'd0, 4'd9, 8'h00);
        chk("R10 nop clears", read_mode, 0);
    endtask

    task automatic t_illegal();
        issue(4'd5, 4'd0, 8'h12);
        chk("R11 undefined code err", s_err, 1);
        chk("R11 wiper0 unchanged", wiper0, 8'h3C);
        chk("R11 wiper1 unchanged", wiper1, 8'hF0);
        chk("R11 read_mode unchanged", read_mode, 0);
        @(negedge clk);
        chk("R11 err one cycle", cmd_err, 0);
        issue(4'd3, 4'd0, 8'h99);
        chk("R11 user write to addr0 err", s_err, 1);
        chk("R11 no busy", busy, 0);
        chk("R11 ready stays", cmd_ready, 1);
        issue(4'd11, 4'd0, 8'h44);
        issue(4'd8, 4'd0, 8'h00);
        chk("R11 backup 0 untouched", wiper0, 8'h3C);
        issue(4'd11, 4'd7, 8'h55);
        chk("R11 load addr7 err", s_err, 1);
        chk("R11 load addr7 wiper0", wiper0, 8'h3C);
        chk("R11 load addr7 wiper1", wiper1, 8'hF0);
        issue(4'd9, 4'd1, 8'h00);
        chk("R11 read addr1 err", s_err, 1);
        chk("R11 read addr1 no rd_valid", s_rdv, 0);
        chk("R11 read addr1 read_mode", read_mode, 0);
        issue(4'd1, 4'd3, 8'h00);
        chk("R11 restore addr3 read_mode", read_mode, 0);
        issue(4'd2, 4'd4, 8'h00);
        chk("R11 save addr4 err", s_err, 1);
        chk("R11 save addr4 no busy", busy, 0);
        issue(4'd9, 4'd4, 8'h00);
        chk("R11 addr4 store untouched", s_rdd, INIT);
        issue(4'd0, 4'd0, 8'h00);
    endtask

    initial begin
        #(5ns * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        t_reset();
        t_load();
        t_save_restore();
        t_user();
        t_illegal();
        report();
    end
endmodule